// File: doc/BRIEF.md
# Register-Indexed Compact Jump-and-Link Unit

This block is the execute-stage next-PC and return-link logic for one register-indexed, compact jump-and-link instruction in a 32-bit RISC pipeline. It decodes the instruction word and forms the jump target. The target is the value read from the source register plus the 16-bit immediate. The immediate is sign-extended and added without any left shift, so every immediate bit lines up with the same bit of the register value. The block asks for a write of the return address (PC + 4) into register 31. It also squashes the instruction that follows, because the jump has no delay slot. The jump is always taken and raises no trap, even when the target is odd.

When the core is configured with an alternate compressed instruction set (`alt_isa_en_i` high), bit 0 of the sum does not stay in the target. The block clears it in the target and loads it into a registered instruction-set mode bit. That bit is held by a two-state machine. State `MODE_BASE` (output 0, the reset state) moves to `MODE_ALT` on a load with value 1. State `MODE_ALT` (output 1) moves back to `MODE_BASE` on a load with value 0. In either state, a load of the same value or no load at all keeps the state. Another instruction shares the major opcode and differs only in bits 25..21. For that word the block does not jump or link, and raises `other_op_o` instead. The register file, the fetch logic and that other instruction's behaviour lie outside this block.

Top module: `rjl_unit`

## Requirements
- R1: With `valid_i` high, a word whose bits 31..26 are 6'b111110 and bits 25..21 are 5'b00000 is a hit. A hit drives `taken_o`, `squash_o` and `link_we_o` to 1 in the same cycle.
- R2: With `valid_i` high, a word with bits 31..26 equal to 6'b111110 and bits 25..21 nonzero drives `other_op_o` to 1. For such a word, `taken_o`, `squash_o`, `link_we_o` and `mode_load_o` stay 0.
- R3: A word with any other value in bits 31..26 drives `taken_o`, `squash_o`, `link_we_o`, `other_op_o` and `mode_load_o` to 0. It also drives `target_o`, `link_data_o` and `mode_load_val_o` to 0.
- R4: The sum is `src_val_i` plus bits 15..0 sign-extended to 32 bits, with no shift, modulo 2^32. With `alt_isa_en_i` low, a hit drives `target_o` to this full sum, odd values included. No trap is raised.
- R5: With `alt_isa_en_i` high, a hit drives `target_o` to the sum with bit 0 cleared. It drives `mode_load_o` to 1 and `mode_load_val_o` to bit 0 of the sum. `isa_mode_o` takes that value after the next rising clock edge.
- R6: On a hit, `link_idx_o` is 31 and `link_data_o` is `pc_i` + 4, modulo 2^32.
- R7: `src_idx_o` always equals bits 20..16 of `instr_i`, whatever the state of `valid_i`.
- R8: With `valid_i` low, every result output is 0 for any word. The result outputs are `taken_o`, `squash_o`, `link_we_o`, `other_op_o`, `mode_load_o`, `target_o`, `link_data_o` and `mode_load_val_o`. `isa_mode_o` keeps its value.
- R9: While `rst_n` is low, and after it is released, `isa_mode_o` is 0 until the first mode load.
- R10: `isa_mode_o` changes only after a cycle with `mode_load_o` high. A hit with `alt_isa_en_i` low does not change it.
- R11: When bits 20..16 select register 31, the target is formed from the `src_val_i` supplied in that cycle, which is the value before the link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the mode register |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | PC of the instruction |
| src_val_i | input | 32 | Value read from the register named by `src_idx_o` |
| alt_isa_en_i | input | 1 | Static: alternate compressed instruction set supported |
| src_idx_o | output | 5 | Source register index (bits 20..16) |
| taken_o | output | 1 | Jump taken |
| target_o | output | 32 | Next PC |
| squash_o | output | 1 | Kill the following instruction |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address register index |
| link_data_o | output | 32 | Return address |
| other_op_o | output | 1 | Same opcode, different instruction |
| mode_load_o | output | 1 | Mode bit is loaded at the next edge |
| mode_load_val_o | output | 1 | Value to load into the mode bit |
| isa_mode_o | output | 1 | Registered instruction-set mode |

## Verification
The assertions check the following on every cycle:
- a hit always comes with squash and a link write to register 31;
- the other-opcode flag never coincides with a jump;
- nothing is active while `valid_i` is low;
- an alternate-set target is even;
- the mode bit moves only after a load, and then to the loaded value.

Some behaviours can only be shown by the bench's scenarios:
- the arithmetic values (negative and unshifted odd offsets, 32-bit wrap of target and link);
- the use of the pre-link value when the source is register 31;
- the mode sequence across successive jumps.

// File: rtl/rjl_pkg.sv
package rjl_pkg;
    localparam int INSTR_W = 32;
    localparam logic [5:0] MAJOR_OPC = 6'b111110;

    typedef enum logic {
        MODE_BASE = 1'b0,
        MODE_ALT  = 1'b1
    } mode_e;

    typedef struct packed {
        logic       hit;
        logic       other;
        logic [4:0] src_idx;
        logic [15:0] imm;
    } dec_t;
endpackage

// File: rtl/rjl_decode.sv
module rjl_decode
    import rjl_pkg::*;
(
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic opc_match;
    logic sel_zero;

    always_comb begin
        opc_match     = (instr_i[31:26] == MAJOR_OPC);
        sel_zero      = (instr_i[25:21] == 5'd0);
        dec_o.hit     = valid_i && opc_match && sel_zero;
        dec_o.other   = valid_i && opc_match && !sel_zero;
        dec_o.src_idx = instr_i[20:16];
        dec_o.imm     = instr_i[15:0];
    end
endmodule

// File: rtl/rjl_target.sv
module rjl_target #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic             alt_i,
    output logic [XLEN-1:0]  target_o,
    output logic             low_bit_o,
    output logic [XLEN-1:0]  ret_o
);
    localparam int EXT_W = XLEN - IMM_W;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] sum;

    always_comb begin
        imm_ext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        sum       = base_i + imm_ext;
        low_bit_o = sum[0];
        target_o  = alt_i ? {sum[XLEN-1:1], 1'b0} : sum;
        ret_o     = pc_i + STEP;
    end
endmodule

// File: rtl/rjl_mode_fsm.sv
module rjl_mode_fsm
    import rjl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic val_i,
    output logic mode_o
);
    mode_e state_q;
    mode_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BASE: if (load_i && val_i)  state_d = MODE_ALT;
            MODE_ALT:  if (load_i && !val_i) state_d = MODE_BASE;
            default:   state_d = MODE_BASE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_BASE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MODE_ALT: mode_o = 1'b1;
            default:  mode_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rjl_unit.sv
module rjl_unit
    import rjl_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IMM_W    = 16,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    src_val_i,
    input  logic               alt_isa_en_i,
    output logic [REG_W-1:0]   src_idx_o,
    output logic               taken_o,
    output logic [XLEN-1:0]    target_o,
    output logic               squash_o,
    output logic               link_we_o,
    output logic [REG_W-1:0]   link_idx_o,
    output logic [XLEN-1:0]    link_data_o,
    output logic               other_op_o,
    output logic               mode_load_o,
    output logic               mode_load_val_o,
    output logic               isa_mode_o
);
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    dec_t            dec;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] ret;
    logic            low_bit;

    rjl_decode u_dec (
        .valid_i (valid_i),
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    rjl_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
        .base_i    (src_val_i),
        .imm_i     (dec.imm),
        .pc_i      (pc_i),
        .alt_i     (alt_isa_en_i),
        .target_o  (tgt),
        .low_bit_o (low_bit),
        .ret_o     (ret)
    );

    always_comb begin
        src_idx_o       = REG_W'(dec.src_idx);
        taken_o         = dec.hit;
        squash_o        = dec.hit;
        link_we_o       = dec.hit;
        link_idx_o      = LINK_IDX;
        target_o        = dec.hit ? tgt : '0;
        link_data_o     = dec.hit ? ret : '0;
        other_op_o      = dec.other;
        mode_load_o     = dec.hit && alt_isa_en_i;
        mode_load_val_o = dec.hit && alt_isa_en_i && low_bit;
    end

    rjl_mode_fsm u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mode_load_o),
        .val_i  (mode_load_val_o),
        .mode_o (isa_mode_o)
    );
endmodule

// File: rtl/rjl_unit_chk.sv
module rjl_unit_chk #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic             alt_isa_en_i,
    input logic             taken_o,
    input logic [XLEN-1:0]  target_o,
    input logic             squash_o,
    input logic             link_we_o,
    input logic [REG_W-1:0] link_idx_o,
    input logic             other_op_o,
    input logic             mode_load_o,
    input logic             mode_load_val_o,
    input logic             isa_mode_o
);
    // R1
    hit_side_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (squash_o && link_we_o));

    // R2
    other_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_op_o |-> (!taken_o && !link_we_o && !squash_o && !mode_load_o));

    // R6
    link_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o == REG_W'(31)));

    // R5
    alt_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && alt_isa_en_i) |-> (target_o[0] == 1'b0 && mode_load_o));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (!taken_o && !squash_o && !link_we_o && !other_op_o && !mode_load_o));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load_o |=> $stable(isa_mode_o));

    // R5
    mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load_o |=> (isa_mode_o == $past(mode_load_val_o)));
endmodule

bind rjl_unit rjl_unit_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .valid_i         (valid_i),
    .alt_isa_en_i    (alt_isa_en_i),
    .taken_o         (taken_o),
    .target_o        (target_o),
    .squash_o        (squash_o),
    .link_we_o       (link_we_o),
    .link_idx_o      (link_idx_o),
    .other_op_o      (other_op_o),
    .mode_load_o     (mode_load_o),
    .mode_load_val_o (mode_load_val_o),
    .isa_mode_o      (isa_mode_o)
);

// File: tb/rjl_unit_bench.sv
module rjl_unit_bench;
    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] src_val_i = '0;
    logic        alt_isa_en_i = 1'b0;
    logic [4:0]  src_idx_o;
    logic        taken_o;
    logic [31:0] target_o;
    logic        squash_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_data_o;
    logic        other_op_o;
    logic        mode_load_o;
    logic        mode_load_val_o;
    logic        isa_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic        taken;
        logic        link;
        logic        other;
        logic        mload;
        logic        mval;
        logic        mode;
        logic [4:0]  sidx;
        logic [31:0] target;
        logic [31:0] ldata;
    } exp_t;

    exp_t sb[$];
    logic model_mode = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rjl_unit u_rjl_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .pc_i(pc_i), .src_val_i(src_val_i), .alt_isa_en_i(alt_isa_en_i),
        .src_idx_o(src_idx_o), .taken_o(taken_o), .target_o(target_o),
        .squash_o(squash_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
        .link_data_o(link_data_o), .other_op_o(other_op_o),
        .mode_load_o(mode_load_o), .mode_load_val_o(mode_load_val_o),
        .isa_mode_o(isa_mode_o)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] sel,
                                       input logic [4:0] rs, input logic [15:0] imm);
        return {op, sel, rs, imm};
    endfunction

    task automatic note(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one vector at a falling edge and queues the expectation.
    task automatic drive(input string tag, input logic v, input logic [31:0] ins,
                         input logic [31:0] pc, input logic [31:0] sv, input logic alt);
        exp_t e;
        logic [31:0] sum;
        logic hit, oth;
        @(negedge clk);
        valid_i = v; instr_i = ins; pc_i = pc; src_val_i = sv; alt_isa_en_i = alt;
        hit = v && ins[31:26] == 6'b111110 && ins[25:21] == 5'd0;
        oth = v && ins[31:26] == 6'b111110 && ins[25:21] != 5'd0;
        sum = sv + {{16{ins[15]}}, ins[15:0]};
        e.tag    = tag;
        e.taken  = hit;
        e.link   = hit;
        e.other  = oth;
        e.mload  = hit && alt;
        e.mval   = hit && alt && sum[0];
        e.mode   = model_mode;
        e.sidx   = ins[20:16];
        e.target = !hit ? 32'd0 : (alt ? {sum[31:1], 1'b0} : sum);
        e.ldata  = hit ? pc + 32'd4 : 32'd0;
        sb.push_back(e);
        if (e.mload) model_mode = e.mval;
    endtask

    // Monitor: samples a quarter period after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (taken_o !== e.taken || squash_o !== e.taken || link_we_o !== e.link ||
                    other_op_o !== e.other || mode_load_o !== e.mload ||
                    mode_load_val_o !== e.mval || isa_mode_o !== e.mode ||
                    src_idx_o !== e.sidx || target_o !== e.target ||
                    link_data_o !== e.ldata || (e.link && link_idx_o !== 5'd31)) begin
                    errors++;
                    $display("FAIL %s flags actual=%b%b%b%b%b%b%b expected=%b%b%b%b%b%b%b target actual=%h expected=%h link actual=%h expected=%h idx actual=%0d expected=%0d",
                        e.tag, taken_o, squash_o, link_we_o, other_op_o, mode_load_o,
                        mode_load_val_o, isa_mode_o, e.taken, e.taken, e.link, e.other,
                        e.mload, e.mval, e.mode, target_o, e.target, link_data_o,
                        e.ldata, src_idx_o, e.sidx);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: mode is base while in reset
        note(isa_mode_o === 1'b0, "R9", "reset mode", {31'd0, isa_mode_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        note(isa_mode_o === 1'b0, "R9", "post-reset mode", {31'd0, isa_mode_o}, 32'd0);

        // R1 R4 R6 R7: basic jump
        drive("R1_R4_R6", 1, mk(6'b111110, 0, 5'd5, 16'h0004), 32'h400, 32'h1000, 0);
        // R4: negative offset
        drive("R4_neg", 1, mk(6'b111110, 0, 5'd7, 16'hFFFC), 32'h800, 32'h2000, 0);
        // R4: unshifted odd offset kept, no trap
        drive("R4_odd", 1, mk(6'b111110, 0, 5'd2, 16'h0003), 32'h10, 32'h100, 0);
        // R4 R6: 32-bit wrap of target and link
        drive("R6_wrap", 1, mk(6'b111110, 0, 5'd9, 16'h0020), 32'hFFFF_FFFC, 32'hFFFF_FFF0, 0);
        // R5: alternate set, odd sum
        drive("R5_odd", 1, mk(6'b111110, 0, 5'd3, 16'h0001), 32'h40, 32'h3000, 1);
        // R3 R10: unrelated opcode, mode shows 1
        drive("R3_R10", 1, mk(6'b001000, 0, 5'd4, 16'h1234), 32'h44, 32'h55, 1);
        // R5: alternate set, even sum
        drive("R5_even", 1, mk(6'b111110, 0, 5'd3, 16'h0000), 32'h48, 32'h4000, 1);
        // R8: valid low with hit encoding; R7 index still follows
        drive("R8_idle", 0, mk(6'b111110, 0, 5'd17, 16'h0001), 32'h4C, 32'h4000, 1);
        // R2: other instruction under same opcode
        drive("R2_other", 1, mk(6'b111110, 5'd3, 5'd6, 16'h0010), 32'h50, 32'h60, 1);
        // R8: other encoding with valid low
        drive("R8_other", 0, mk(6'b111110, 5'd3, 5'd6, 16'h0010), 32'h50, 32'h60, 1);
        // R11: source is register 31, pre-link value used
        drive("R11", 1, mk(6'b111110, 0, 5'd31, 16'h0010), 32'h8000, 32'h5550, 0);
        // R5: go to alternate mode again
        drive("R5_set", 1, mk(6'b111110, 0, 5'd1, 16'h0005), 32'h90, 32'h7000, 1);
        // R10: alternate off, odd sum, no mode change
        drive("R10_off", 1, mk(6'b111110, 0, 5'd1, 16'h0001), 32'h94, 32'h7000, 0);
        // R7 R10: idle with mode observed
        drive("R7_R10", 0, mk(6'b000000, 0, 5'd12, 16'h0000), 32'h98, 32'h0, 0);
        drive("R10_end", 0, 32'h0, 32'h0, 32'h0, 0);

        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule